// File: doc/BRIEF.md
# Zero-Cross Gated Gain Register

This block keeps the gain code of an input programmable-gain stage. It also decides the moment at which a new code from the host replaces the active one. A host write does not change the gain at once. The new code is parked as pending. It is applied on the first signal zero crossing seen in the sample stream, or when a timeout counted in sample strobes expires, whichever comes first. Applying a gain step only at a crossing keeps audible clicks out of the signal path. The timeout sets an upper bound on how long a quiet or DC-offset input can hold a change back.

The block also has a power-enable input. While power is off, the gain is held at its default code, and after power returns there is a short warm-up of two sample strobes. An automatic-level-control mode lets an external loop drive the gain directly. When that mode is left, the block keeps the last code that the loop supplied.

The controller is one state machine with these states:
- OFF: no power, gain at its default.
- WARM: waiting out the warm-up strobes.
- IDLE: manual mode with nothing pending.
- WAIT: manual mode with a code pending.
- AUTO: the level-control loop drives the gain.

The transitions are:
- power-up: OFF to WARM, when `pwr_en` rises.
- warm-done: WARM to IDLE, or to AUTO if `alc_en` is 1, on the second strobe.
- host-write: IDLE to WAIT, or WAIT to WAIT with the timer restarted.
- apply: WAIT to IDLE, on a zero crossing or a timeout.
- auto-enter: IDLE or WAIT to AUTO.
- auto-leave: AUTO to IDLE.
- power-down: any state to OFF.

Top module: `zc_gain_hold`

## Requirements
- R1: After reset, and one clock after any edge where `pwr_en` is 0, `gain_out` is 0x10 (0 dB; 0.5 dB per code step, 0x00 = -8 dB) and `pending` is 0.
- R2: `gain_out` never exceeds 0x47. A host code or level-control code above 0x47 is taken as 0x47.
- R3: A host write (`wr_en` high at a clock edge) is taken only when power is on, the warm-up is over, and `alc_en` is 0. Otherwise it changes neither `gain_out` nor `pending`.
- R4: After `pwr_en` rises, writes are ignored until two sample strobes have been seen. The strobe on the clock edge where `pwr_en` first reads 1 does not count toward the two.
- R5: A taken write sets `pending` on that edge. `gain_out` keeps its old value while `pending` is 1.
- R6: A strobe counts as a zero crossing when its sample is zero, or when its sign bit (bit SAMP_W-1) differs from that of the previous strobed sample. The previous sample is taken as 0 after power-up. A crossing strobe applies the pending code and clears `pending` on that edge.
- R7: With no crossing, the pending code is applied on the N-th strobe after the write, where N is 128, 256, 512 or 1024 for `tmo_sel` = 0, 1, 2 or 3.
- R8: A write made while a code is pending replaces that code and restarts the strobe count from zero. A write on the same edge as a crossing or timeout strobe takes priority.
- R9: In AUTO with `alc_en` 1, `gain_out` takes the (clamped) `alc_gain` on every edge. Entering AUTO clears `pending` and drops the parked code.
- R10: When `alc_en` falls in AUTO, `gain_out` keeps the last level-control code, and later `alc_gain` changes have no effect.
- R11: After a power cycle, operation restarts from 0x10 with a fresh warm-up. No gain or pending code survives the power cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Power enable of the gain stage |
| alc_en | input | 1 | Automatic level control active |
| alc_gain | input | 7 | Gain code from the level-control loop |
| tmo_sel | input | 2 | Timeout select: 128 << tmo_sel strobes |
| smp_stb | input | 1 | One-cycle sample-rate strobe |
| smp | input | 16 | Signed sample, two's complement |
| wr_en | input | 1 | Host write strobe |
| wr_code | input | 7 | Host gain code |
| gain_out | output | 7 | Active gain code |
| pending | output | 1 | A host code waits to be applied |

## Verification
The deferral is tried with three kinds of sample stream. Runs of one sign isolate the timeout path, which separates the 128-strobe window from the 256-strobe window. A single sign flip proves that a crossing beats the timer. An exact zero sample proves that zero counts as a crossing even when the sign bit stays the same. A second write in the middle of a window separates a restarted timer from a free-running one. A long random phase, with sparse crossings, writes, mode toggles and power toggles, is compared on every cycle against a bench model. That comparison exposes the ordering between a write, a crossing and a mode change that land on the same edge.

// File: rtl/zgr_pkg.sv
package zgr_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_IDLE,
        ST_WAIT,
        ST_AUTO
    } zgr_state_e;
endpackage

// File: rtl/zgr_zc_detect.sv
module zgr_zc_detect #(
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [SAMP_W-1:0] smp,
    output logic              zc
);
    localparam int MSB = SAMP_W - 1;

    logic prev_sign;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_sign <= 1'b0;
        else if (clr)
            prev_sign <= 1'b0;
        else if (stb)
            prev_sign <= smp[MSB];
    end

    assign zc = stb & ((smp == '0) | (smp[MSB] ^ prev_sign));
endmodule

// File: rtl/zgr_tick_counter.sv
module zgr_tick_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/zc_gain_hold.sv
module zc_gain_hold
    import zgr_pkg::*;
#(
    parameter int              GAIN_W   = 7,
    parameter int              SAMP_W   = 16,
    parameter int              TMO_BASE = 128,
    parameter int              WARMUP   = 2,
    parameter logic [GAIN_W-1:0] DEF_CODE = 7'h10,
    parameter logic [GAIN_W-1:0] MAX_CODE = 7'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              alc_en,
    input  logic [GAIN_W-1:0] alc_gain,
    input  logic [1:0]        tmo_sel,
    input  logic              smp_stb,
    input  logic [SAMP_W-1:0] smp,
    input  logic              wr_en,
    input  logic [GAIN_W-1:0] wr_code,
    output logic [GAIN_W-1:0] gain_out,
    output logic              pending
);
    localparam int CNT_W = $clog2(TMO_BASE * 8) + 1;
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARMUP - 1);

    zgr_state_e state, state_nx;

    logic [GAIN_W-1:0] park_code;
    logic [CNT_W-1:0]  tick_cnt;
    logic [CNT_W-1:0]  tmo_len;
    logic [CNT_W-1:0]  tmo_last;
    logic              zc_hit;
    logic              st_off, st_wait, st_auto, st_manual;
    logic              wr_take, tmo_hit, apply_hit, cnt_clr;
    logic [GAIN_W-1:0] wr_clamped, alc_clamped;

    assign st_off    = (state == ST_OFF);
    assign st_wait   = (state == ST_WAIT);
    assign st_auto   = (state == ST_AUTO);
    assign st_manual = (state == ST_IDLE) | st_wait;

    assign wr_clamped  = (wr_code  > MAX_CODE) ? MAX_CODE : wr_code;
    assign alc_clamped = (alc_gain > MAX_CODE) ? MAX_CODE : alc_gain;

    assign tmo_len  = CNT_W'(TMO_BASE) << tmo_sel;
    assign tmo_last = tmo_len - CNT_W'(1);

    assign wr_take   = pwr_en & ~alc_en & st_manual & wr_en;
    assign tmo_hit   = smp_stb & (tick_cnt == tmo_last);
    assign apply_hit = pwr_en & ~alc_en & st_wait & ~wr_en & (zc_hit | tmo_hit);
    assign cnt_clr   = st_off | wr_take;

    zgr_zc_detect #(.SAMP_W(SAMP_W)) u_zc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_off),
        .stb   (smp_stb),
        .smp   (smp),
        .zc    (zc_hit)
    );

    zgr_tick_counter #(.CNT_W(CNT_W)) u_ticks (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (smp_stb),
        .count (tick_cnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  state_nx = ST_WARM;                                  // power-up
            ST_WARM: if (smp_stb && tick_cnt == WARM_LAST)
                         state_nx = alc_en ? ST_AUTO : ST_IDLE;           // warm-done
            ST_IDLE: if (alc_en)      state_nx = ST_AUTO;                 // auto-enter
                     else if (wr_en)  state_nx = ST_WAIT;                 // host-write
            ST_WAIT: if (alc_en)      state_nx = ST_AUTO;                 // auto-enter
                     else if (wr_en)  state_nx = ST_WAIT;                 // host-write
                     else if (apply_hit) state_nx = ST_IDLE;              // apply
            ST_AUTO: if (!alc_en)     state_nx = ST_IDLE;                 // auto-leave
            default: state_nx = ST_OFF;
        endcase
        if (!pwr_en)
            state_nx = ST_OFF;                                            // power-down
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_out  <= DEF_CODE;
            pending   <= 1'b0;
            park_code <= DEF_CODE;
        end else if (!pwr_en || st_off) begin
            gain_out  <= DEF_CODE;
            pending   <= 1'b0;
        end else if (st_auto) begin
            if (alc_en)
                gain_out <= alc_clamped;
        end else if (st_manual) begin
            if (alc_en) begin
                pending <= 1'b0;
            end else if (wr_take) begin
                park_code <= wr_clamped;
                pending   <= 1'b1;
            end else if (apply_hit) begin
                gain_out <= park_code;
                pending  <= 1'b0;
            end
        end
    end
endmodule

module zgr_checker #(
    parameter int                GAIN_W   = 7,
    parameter logic [GAIN_W-1:0] DEF_CODE = 7'h10,
    parameter logic [GAIN_W-1:0] MAX_CODE = 7'h47
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_en,
    input logic              alc_en,
    input logic              wr_en,
    input logic              smp_stb,
    input logic              in_auto,
    input logic [GAIN_W-1:0] alc_gain,
    input logic [GAIN_W-1:0] gain_out,
    input logic              pending
);
    a_r1_off_default: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (gain_out == DEF_CODE && !pending));

    a_r2_gain_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        gain_out <= MAX_CODE);

    a_r3_pending_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !wr_en) |=> !pending);

    a_r5_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && pwr_en && !alc_en && !smp_stb) |=> $stable(gain_out));

    a_r9_auto_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_auto && pwr_en && alc_en) |=>
            (!pending && (gain_out == $past(alc_gain) ||
                          ($past(alc_gain) > MAX_CODE && gain_out == MAX_CODE))));

    a_r10_auto_leave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_auto && pwr_en && !alc_en) |=> $stable(gain_out));
endmodule

bind zc_gain_hold zgr_checker #(
    .GAIN_W   (GAIN_W),
    .DEF_CODE (DEF_CODE),
    .MAX_CODE (MAX_CODE)
) u_zgr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_en   (pwr_en),
    .alc_en   (alc_en),
    .wr_en    (wr_en),
    .smp_stb  (smp_stb),
    .in_auto  (st_auto),
    .alc_gain (alc_gain),
    .gain_out (gain_out),
    .pending  (pending)
);

// File: tb/tb_zc_gain_hold.sv
module tb_zc_gain_hold;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0;
    logic        alc_en = 1'b0;
    logic [6:0]  alc_gain = '0;
    logic [1:0]  tmo_sel = '0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_code = '0;
    logic [6:0]  gain_out;
    logic        pending;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1 reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_gain_hold dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .alc_en(alc_en),
        .alc_gain(alc_gain), .tmo_sel(tmo_sel), .smp_stb(smp_stb), .smp(smp),
        .wr_en(wr_en), .wr_code(wr_code), .gain_out(gain_out), .pending(pending)
    );

    function automatic logic [6:0] clampf(input logic [6:0] c);
        return (c > 7'h47) ? 7'h47 : c;
    endfunction

    // bench model of the requirements
    logic [6:0]  m_gain, m_pcode;
    logic        m_pend, m_on, m_ready, m_auto;
    logic [15:0] m_prev;
    int          m_warm, m_tcnt;
    logic        m_zc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gain = 7'h10; m_pcode = 7'h10; m_pend = 0; m_on = 0; m_ready = 0;
            m_auto = 0; m_prev = '0; m_warm = 0; m_tcnt = 0;
        end else if (!pwr_en) begin
            m_gain = 7'h10; m_pend = 0; m_on = 0; m_ready = 0;
            m_auto = 0; m_prev = '0; m_warm = 0; m_tcnt = 0;
        end else if (!m_on) begin
            m_on = 1;
        end else begin
            m_zc = smp_stb && (smp == 16'h0 || smp[15] != m_prev[15]);
            if (!m_ready) begin
                if (smp_stb) begin
                    m_warm++;
                    if (m_warm == 2) begin m_ready = 1; m_auto = alc_en; end
                end
            end else if (m_auto) begin
                if (alc_en) m_gain = clampf(alc_gain);
                else        m_auto = 0;
            end else if (alc_en) begin
                m_auto = 1; m_pend = 0;
            end else if (wr_en) begin
                m_pcode = clampf(wr_code); m_pend = 1; m_tcnt = 0;
            end else if (m_pend && smp_stb) begin
                if (m_zc || m_tcnt == (128 << tmo_sel) - 1) begin
                    m_gain = m_pcode; m_pend = 0;
                end else begin
                    m_tcnt++;
                end
            end
            if (smp_stb) m_prev = smp;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (gain_out !== m_gain || pending !== m_pend) begin
                bad++;
                $display("FAIL %s model: gain=%h pend=%b expected gain=%h pend=%b",
                         tag, gain_out, pending, m_gain, m_pend);
            end
        end
    end

    task automatic check(input string req, input logic [6:0] eg, input logic ep);
        total++;
        if (gain_out !== eg || pending !== ep) begin
            bad++;
            $display("FAIL %s: gain=%h pend=%b expected gain=%h pend=%b",
                     req, gain_out, pending, eg, ep);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] v);
        @(negedge clk); smp = v; smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
    endtask

    task automatic strobes(input int n, input logic [15:0] v);
        for (int i = 0; i < n; i++) strobe(v);
    endtask

    task automatic write(input logic [6:0] c);
        @(negedge clk); wr_en = 1'b1; wr_code = c;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: expired, expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        tag = "R1 reset";
        check("R1 reset state", 7'h10, 1'b0);

        tag = "R4 warmup";
        pwr_en = 1'b1;
        cyc(1);
        write(7'h33);
        check("R4 write during warm-up ignored", 7'h10, 1'b0);
        check("R3 write before ready ignored", 7'h10, 1'b0);
        strobes(2, 16'd100);

        tag = "R5 pending";
        write(7'h7F);
        check("R5 pending set, gain held", 7'h10, 1'b1);
        tag = "R7 timeout";
        strobes(127, 16'd50);
        check("R7 not applied before 128 strobes", 7'h10, 1'b1);
        strobe(16'd50);
        check("R7 applied on 128th strobe", 7'h47, 1'b0);
        check("R2 clamp of 0x7F to 0x47", 7'h47, 1'b0);

        tag = "R6 crossing";
        write(7'h20);
        strobe(-16'sd5);
        check("R6 sign change applies", 7'h20, 1'b0);
        write(7'h05);
        strobe(-16'sd9);
        check("R6 same sign does not apply", 7'h20, 1'b1);
        strobe(16'd0);
        check("R6 zero sample applies", 7'h05, 1'b0);

        tag = "R8 rewrite";
        write(7'h30);
        strobes(100, 16'd7);
        write(7'h31);
        strobes(127, 16'd7);
        check("R8 timer restarted by rewrite", 7'h05, 1'b1);
        strobe(16'd7);
        check("R8 replaced code applied", 7'h31, 1'b0);

        tag = "R7 timeout 256";
        tmo_sel = 2'd1;
        write(7'h12);
        strobes(255, 16'd7);
        check("R7 sel=1 not applied at 255", 7'h31, 1'b1);
        strobe(16'd7);
        check("R7 sel=1 applied at 256", 7'h12, 1'b0);

        tag = "R9 auto";
        write(7'h3A);
        alc_en = 1'b1; alc_gain = 7'h22;
        cyc(3);
        check("R9 auto follows, pending dropped", 7'h22, 1'b0);
        write(7'h40);
        check("R3 write ignored in auto", 7'h22, 1'b0);
        alc_gain = 7'h60;
        cyc(2);
        check("R2 auto code clamped", 7'h47, 1'b0);

        tag = "R10 leave auto";
        alc_gain = 7'h2A;
        cyc(2);
        alc_en = 1'b0; alc_gain = 7'h01;
        cyc(3);
        check("R10 last auto gain kept", 7'h2A, 1'b0);
        strobes(130, 16'd9);
        check("R10 nothing applied after leaving auto", 7'h2A, 1'b0);

        tag = "R11 power cycle";
        tmo_sel = 2'd0;
        write(7'h15);
        pwr_en = 1'b0;
        cyc(2);
        check("R11 power off forces default", 7'h10, 1'b0);
        pwr_en = 1'b1;
        cyc(1);
        write(7'h25);
        strobe(16'd0);
        check("R11 restart from default, warm-up again", 7'h10, 1'b0);

        tag = "R7 random";
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            smp_stb = ($urandom % 2) == 0;
            if (($urandom % 120) == 0) smp = {~smp[15], 15'($urandom % 300)};
            else if (($urandom % 250) == 0) smp = '0;
            else smp = {smp[15], 15'($urandom % 300 + 1)};
            wr_en = ($urandom % 20) == 0;
            wr_code = 7'($urandom);
            alc_gain = 7'($urandom);
            if (($urandom % 300) == 0) alc_en = ~alc_en;
            if (($urandom % 900) == 0) pwr_en = ~pwr_en;
            if (!pwr_en && ($urandom % 8) == 0) pwr_en = 1'b1;
            if (($urandom % 400) == 0) tmo_sel = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; smp_stb = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule